// File: doc/BRIEF.md
# Paired-Group Rename Map

This block is the register rename map of an out-of-order core with 128 architectural registers and 512 physical registers. The physical file is cut into 64 groups of eight slots. Architectural registers 2k and 2k+1 share group k and may only ever be given a slot in that group. The map therefore keeps just a 3-bit slot index per architectural register. A physical number is never stored: it is built by placing the architectural number shifted right by one above the 3-bit index.

Rename hands out the lowest free slot of the destination pair's group in the same cycle the request is seen. If that group is full, the request stalls, even when other groups still have room. Source lookups read the map without delay. A release port returns a slot to its group's free set when the instruction that overwrote it commits. Branch checkpoints, operand values and commit ordering belong to other blocks.

Top module: `pair_rat`

## Requirements
- R1: After reset, source lookup of architectural register a returns physical number {a>>1, a[0]} (slot 0 for even a, slot 1 for odd a), and slots 2 to 7 of every group are free.
- R2: A source lookup of register a returns the 9-bit physical number formed as {a[6:1], idx[a]}, group number in bits 8:3 and slot index in bits 2:0.
- R3: When ren_valid_i is high and the group ren_arch_i[6:1] has a free slot, ren_grant_o is high in the same cycle and ren_phys_o is {ren_arch_i[6:1], s}, where s is the lowest-numbered free slot of that group.
- R4: After a granted rename, from the next cycle on, lookups of the renamed register return the new physical number, and lookups of its pair partner are unchanged.
- R5: A source lookup in the same cycle as a rename of the same register returns the mapping from before the rename.
- R6: When ren_valid_i is high and the group has no free slot, ren_stall_o is high and ren_grant_o low, regardless of free slots in other groups; the map and the free slots are left unchanged.
- R7: A release of physical number p marks slot p[2:0] of group p[8:3] free from the next cycle; a rename in the same cycle as the release does not yet see the freed slot.
- R8: A release and a granted rename to the same group in the same cycle both take effect: the granted slot becomes busy and the released slot becomes free.
- R9: With ren_valid_i low, ren_grant_o and ren_stall_o are low and no map entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ren_valid_i | input | 1 | Rename request present |
| ren_arch_i | input | 7 | Destination architectural register |
| ren_grant_o | output | 1 | Rename granted this cycle |
| ren_stall_o | output | 1 | Rename refused: pair group full |
| ren_phys_o | output | 9 | Newly assigned physical number (valid with grant) |
| src_arch_i | input | 14 | Two source architectural registers, port n in bits 7n+6:7n |
| src_phys_o | output | 18 | Two physical numbers, port n in bits 9n+8:9n |
| rel_valid_i | input | 1 | Release request present |
| rel_phys_i | input | 9 | Physical number to return to its group |

## Verification
Release and allocation can strike the same group in one cycle. The bench fills every group, then frees one slot while a rename to that group is presented. In the first case, the group is full, and the rename must still stall. In the second case, a slot was freed a cycle earlier, so the rename is granted that slot while another slot is released. The following renames must receive exactly the slots the bench's own free-set arithmetic predicts, which shows that neither update was lost.

// File: rtl/prt_pkg.sv
// Shared types for the paired-group rename map.
package prt_pkg;
    // Outcome of a rename request in the current cycle.
    typedef enum logic [1:0] {
        REN_IDLE  = 2'd0,
        REN_GRANT = 2'd1,
        REN_STALL = 2'd2
    } ren_outcome_e;
endpackage

// File: rtl/prt_slot_pick.sv
// Lowest-free-slot finder.
// Takes a group's free mask and returns whether any slot is free and the
// index of the lowest free one. Purely combinational.
module prt_slot_pick #(
    parameter int SLOTS = 8,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic [SLOTS-1:0] free_mask_i,
    output logic             any_free_o,
    output logic [SW-1:0]    slot_o
);
    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        any_free_o = |free_mask_i;
        slot_o     = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (free_mask_i[i]) slot_o = SW'(i);
        end
    end
endmodule

// File: rtl/prt_group.sv
// Free-slot tracker for one group of physical registers.
// Holds one bit per slot (1 = free). Assumes the caller only allocates a
// free slot and only releases a busy one; both may happen in one cycle.
module prt_group #(
    parameter int SLOTS = 8,
    parameter int RESERVED = 2,
    localparam int SW = $clog2(SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en_i,
    input  logic [SW-1:0]    alloc_slot_i,
    input  logic             rel_en_i,
    input  logic [SW-1:0]    rel_slot_i,
    output logic [SLOTS-1:0] free_mask_o
);
    localparam logic [SLOTS-1:0] INIT_MASK = ~((SLOTS)'((1 << RESERVED) - 1));

    logic [SLOTS-1:0] clr_vec;
    logic [SLOTS-1:0] set_vec;

    // Decode the one-hot clear and set vectors for this cycle.
    always_comb begin
        clr_vec = '0;
        set_vec = '0;
        if (alloc_en_i) clr_vec[alloc_slot_i] = 1'b1;
        if (rel_en_i)   set_vec[rel_slot_i]   = 1'b1;
    end

    // Apply allocation and release together.
    always_ff @(posedge clk) begin
        if (!rst_n) free_mask_o <= INIT_MASK;
        else        free_mask_o <= (free_mask_o & ~clr_vec) | set_vec;
    end

    p_alloc_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en_i |-> free_mask_o[alloc_slot_i]);
    p_alloc_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en_i && !(rel_en_i && rel_slot_i == alloc_slot_i))
        |=> !free_mask_o[$past(alloc_slot_i)]);
    p_release_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_en_i |=> free_mask_o[$past(rel_slot_i)]);
    p_both_apply_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en_i && rel_en_i && !free_mask_o[rel_slot_i])
        |=> ($countones(free_mask_o) == $countones($past(free_mask_o))));
endmodule

// File: rtl/prt_index_map.sv
// Slot-index store, one entry per architectural register.
// Write takes effect at the clock edge; reads are combinational, so a read
// in the write cycle sees the old index.
module prt_index_map #(
    parameter int ARCH = 128,
    parameter int SW = 3,
    parameter int NUM_SRC = 2,
    localparam int AW = $clog2(ARCH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en_i,
    input  logic [AW-1:0]         wr_arch_i,
    input  logic [SW-1:0]         wr_idx_i,
    input  logic [NUM_SRC*AW-1:0] rd_arch_i,
    output logic [NUM_SRC*SW-1:0] rd_idx_o
);
    logic [SW-1:0] idx_q [ARCH];

    // Reset each entry to its parity slot; otherwise store the new index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < ARCH; a++) idx_q[a] <= SW'(a % 2);
        end else if (wr_en_i) begin
            idx_q[wr_arch_i] <= wr_idx_i;
        end
    end

    // One read port per source.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_rd
        assign rd_idx_o[s*SW +: SW] = idx_q[rd_arch_i[s*AW +: AW]];
    end

    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (idx_q[$past(wr_arch_i)] == $past(wr_idx_i)));
endmodule

// File: rtl/pair_rat.sv
// Paired-group register alias table (top).
// Architectural registers 2k and 2k+1 share physical group k. Rename takes
// the lowest free slot of the pair's group or stalls; lookups concatenate
// group and slot; releases return slots. Assumes releases name busy slots.
module pair_rat #(
    parameter int ARCH = 128,
    parameter int SLOTS = 8,
    parameter int NUM_SRC = 2,
    localparam int GROUPS = ARCH / 2,
    localparam int AW = $clog2(ARCH),
    localparam int SW = $clog2(SLOTS),
    localparam int GW = $clog2(GROUPS),
    localparam int PW = GW + SW
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ren_valid_i,
    input  logic [AW-1:0]         ren_arch_i,
    output logic                  ren_grant_o,
    output logic                  ren_stall_o,
    output logic [PW-1:0]         ren_phys_o,
    input  logic [NUM_SRC*AW-1:0] src_arch_i,
    output logic [NUM_SRC*PW-1:0] src_phys_o,
    input  logic                  rel_valid_i,
    input  logic [PW-1:0]         rel_phys_i
);
    import prt_pkg::*;

    logic [SLOTS-1:0]       free_masks [GROUPS];
    logic [GW-1:0]          ren_group;
    logic [GW-1:0]          rel_group;
    logic [SLOTS-1:0]       sel_mask;
    logic                   sel_any;
    logic [SW-1:0]          sel_slot;
    ren_outcome_e           outcome;
    logic [NUM_SRC*SW-1:0]  src_idx;

    assign ren_group = ren_arch_i[AW-1:1];
    assign rel_group = rel_phys_i[PW-1:SW];
    assign sel_mask  = free_masks[ren_group];

    prt_slot_pick #(.SLOTS(SLOTS)) u_pick (
        .free_mask_i (sel_mask),
        .any_free_o  (sel_any),
        .slot_o      (sel_slot)
    );

    // Classify the rename request.
    always_comb begin
        if (!ren_valid_i)  outcome = REN_IDLE;
        else if (sel_any)  outcome = REN_GRANT;
        else               outcome = REN_STALL;
    end

    assign ren_grant_o = (outcome == REN_GRANT);
    assign ren_stall_o = (outcome == REN_STALL);
    assign ren_phys_o  = {ren_group, sel_slot};

    // One free-slot tracker per group.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        prt_group #(.SLOTS(SLOTS), .RESERVED(2)) u_grp (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc_en_i   (ren_grant_o && (ren_group == GW'(g))),
            .alloc_slot_i (sel_slot),
            .rel_en_i     (rel_valid_i && (rel_group == GW'(g))),
            .rel_slot_i   (rel_phys_i[SW-1:0]),
            .free_mask_o  (free_masks[g])
        );
    end

    prt_index_map #(.ARCH(ARCH), .SW(SW), .NUM_SRC(NUM_SRC)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (ren_grant_o),
        .wr_arch_i (ren_arch_i),
        .wr_idx_i  (sel_slot),
        .rd_arch_i (src_arch_i),
        .rd_idx_o  (src_idx)
    );

    // Build each source physical number from pair group and slot index.
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        assign src_phys_o[s*PW +: PW] =
            {src_arch_i[s*AW+1 +: AW-1], src_idx[s*SW +: SW]};
    end

    p_grant_stall_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ren_grant_o, ren_stall_o}));
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ren_valid_i |-> !(ren_grant_o || ren_stall_o));
    p_stall_holds_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_stall_o && !(rel_valid_i && rel_group == ren_group))
        |=> $stable(ren_stall_o) || !ren_valid_i || ($past(ren_arch_i) != ren_arch_i)
            || (free_masks[ren_group] == '0));
endmodule

// File: tb/pair_rat_tb_top.sv
// Self-checking bench: full sweep of all 64 groups with a reference
// free-set and index model kept in the bench.
module pair_rat_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ren_valid_i = 1'b0;
    logic [6:0]  ren_arch_i = '0;
    logic        ren_grant_o;
    logic        ren_stall_o;
    logic [8:0]  ren_phys_o;
    logic [13:0] src_arch_i = '0;
    logic [17:0] src_phys_o;
    logic        rel_valid_i = 1'b0;
    logic [8:0]  rel_phys_i = '0;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    logic [7:0] m_mask [64];
    logic [2:0] m_idx [128];

    always #5 clk = ~clk;

    pair_rat dut_i (
        .clk(clk), .rst_n(rst_n),
        .ren_valid_i(ren_valid_i), .ren_arch_i(ren_arch_i),
        .ren_grant_o(ren_grant_o), .ren_stall_o(ren_stall_o),
        .ren_phys_o(ren_phys_o),
        .src_arch_i(src_arch_i), .src_phys_o(src_phys_o),
        .rel_valid_i(rel_valid_i), .rel_phys_i(rel_phys_i)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int low_free(input logic [7:0] m);
        for (int i = 0; i < 8; i++) if (m[i]) return i;
        return 0;
    endfunction

    // Drive one cycle at the falling edge, check combinational outputs,
    // then advance the model as the rising edge will.
    task automatic step(input bit rv, input int ra, input bit lv, input int lp,
                        input int s0, input int s1,
                        input string rtag, input string stag);
        int g;
        bit eg;
        int es;
        @(negedge clk);
        ren_valid_i = rv;
        ren_arch_i  = 7'(ra);
        rel_valid_i = lv;
        rel_phys_i  = 9'(lp);
        src_arch_i  = {7'(s1), 7'(s0)};
        #1;
        g  = ra / 2;
        eg = rv && (m_mask[g] != 0);
        es = low_free(m_mask[g]);
        chk({rtag, " grant"}, int'(ren_grant_o), int'(eg));
        chk({rtag, " stall"}, int'(ren_stall_o), int'(rv && !eg));
        if (eg) chk({rtag, " phys"}, int'(ren_phys_o), g * 8 + es);
        chk({stag, " src0"}, int'(src_phys_o[8:0]),  (s0 / 2) * 8 + int'(m_idx[s0]));
        chk({stag, " src1"}, int'(src_phys_o[17:9]), (s1 / 2) * 8 + int'(m_idx[s1]));
        if (eg) begin
            m_mask[g][es] = 1'b0;
            m_idx[ra] = 3'(es);
        end
        if (lv) m_mask[lp / 8][lp % 8] = 1'b1;
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("  test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int g = 0; g < 64; g++) m_mask[g] = 8'hFC;
        for (int a = 0; a < 128; a++) m_idx[a] = 3'(a % 2);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset mapping of every register, two per cycle.
        for (int k = 0; k < 64; k++) step(0, 2 * k, 0, 0, 2 * k, 2 * k + 1, "R9", "R1");

        for (int g = 0; g < 64; g++) begin
            int ev;
            int od;
            ev = 2 * g;
            od = 2 * g + 1;
            // R3/R5/R4: six alternating renames take slots 2..7 in order;
            // src0 sees the old mapping, src1 the partner's latest one.
            for (int n = 0; n < 6; n++) begin
                int ra;
                ra = (n % 2 == 0) ? ev : od;
                step(1, ra, 0, 0, ra, (ra == ev) ? od : ev, "R3", "R5");
            end
            // R6: group full, other groups untouched still have room.
            step(1, ev, 0, 0, ev, od, "R6", "R4");
            step(0, ev, 0, 0, ev, od, "R9", "R6");
            // R7: release slot 0 with a rename in the same cycle -> stall.
            step(1, od, 1, g * 8 + 0, od, ev, "R7", "R2");
            // R7: next cycle the freed slot is granted.
            step(1, od, 0, 0, od, ev, "R7", "R5");
            step(0, 0, 1, g * 8 + 1, od, ev, "R9", "R4");
            // R8: grant slot 1 while releasing slot 4 in one cycle.
            step(1, ev, 1, g * 8 + 4, ev, od, "R8", "R5");
            step(1, ev, 0, 0, ev, od, "R8", "R4");
            step(1, ev, 0, 0, ev, od, "R6", "R2");
        end

        // R9: idle request leaves every mapping unchanged.
        step(0, 5, 0, 0, 5, 4, "R9", "R9");
        for (int k = 0; k < 64; k++) step(0, 2 * k, 0, 0, 2 * k, 2 * k + 1, "R9", "R2");

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule